// File: doc/BRIEF.md
# Priority Load-Shed Sequencer

This block sheds load quickly across a group of power ports when the main supply is overloaded. Each port carries a priority bit and reports whether it is powered. When the active-low shed request falls, the block turns off every powered low-priority port, one port at a time. It works in ascending port order and keeps a minimum spacing between turn-offs, so the supply sees no step that is too large. The whole sequence ends well inside a fixed latency bound.

Each shed port receives a one-cycle turn-off pulse. At the same time it receives a one-cycle pulse that clears its detection and classification enables, so it stays off until the host turns those enables on again. Separately, each port has an active-low hardware kill pin. That pin forces the port's turn-off output in the same cycle, with no synchroniser and no sequencing.

Top module: `shed_seq`

## Requirements
- R1: After reset, `port_off` and `en_clr` are all zero while every `hw_off_n` bit is high.
- R2: Only ports whose `prio_hi` bit is 0 (low priority) are shed; a port with `prio_hi` = 1 never receives a shed pulse.
- R3: Two successive shed pulses are exactly `GAP_CYC` clock cycles apart, and never closer.
- R4: Ports are shed in ascending index order (bit 0 first).
- R5: A low-priority port that is not powered (`port_on` = 0) is skipped and uses no spacing slot: the next powered low-priority port takes that slot.
- R6: The first shed pulse is visible on the 4th rising clock edge after `shed_n` is sampled low. The total latency stays within `LIMIT_CYC` cycles.
- R7: A shed pulse lasts one cycle, at most one port is pulsed at a time, and `port_off[i]` and `en_clr[i]` pulse together for the shed port.
- R8: If `shed_n` returns high while a sequence is running, the sequence still sheds every remaining port.
- R9: `hw_off_n[i]` = 0 drives `port_off[i]` high in the same cycle, combinationally, and does not pulse `en_clr`.
- R10: Only a falling edge of `shed_n` starts a sequence. While `shed_n` stays low after a sequence, ports that power up are not shed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prio_hi | input | NPORTS | Per-port priority, 1 = high (never shed) |
| port_on | input | NPORTS | Per-port powered status |
| shed_n | input | 1 | Active-low asynchronous shed request |
| hw_off_n | input | NPORTS | Per-port active-low hardware kill |
| port_off | output | NPORTS | Turn-off command: shed pulse or hardware kill |
| en_clr | output | NPORTS | One-cycle clear of detect/class enables |

## Verification
The sequence is exercised with four priority and power patterns:
- All ports low priority and powered, which gives the full four-slot spacing and the ascending order.
- Alternating priority, which shows that high-priority ports are excluded.
- Unpowered low-priority ports, which shows that skipped ports consume no slot.
- All ports high priority, which shows that nothing is shed.

A release of the request in mid-sequence shows that the sequence runs to completion. Powering ports while the request is held low shows that only an edge starts a sequence. A hardware kill is checked in the same cycle it is applied, to confirm it acts without the enable clear.

// File: rtl/shed_pkg.sv
package shed_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } shed_st_e;
endpackage

// File: rtl/shed_edge_sync.sv
module shed_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    output logic fall
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], req_n};
        prev_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/shed_gap_timer.sv
module shed_gap_timer #(
    parameter int GAP_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = GW'(GAP_CYC - 1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready = (cnt_q == '0);

    // spacing: a new slot is only taken once the previous gap has run out
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ready);
endmodule

// File: rtl/shed_lowest_pick.sv
module shed_lowest_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic [N-1:0] at_or_below
);
    always_comb begin
        logic found;
        found       = 1'b0;
        grant       = '0;
        at_or_below = '0;
        for (int i = 0; i < N; i++) begin
            at_or_below[i] = !found;
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/shed_seq.sv
module shed_seq
    import shed_pkg::*;
#(
    parameter int NPORTS      = 4,
    parameter int GAP_CYC     = 60,
    parameter int LIMIT_CYC   = 650,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] prio_hi,
    input  logic [NPORTS-1:0] port_on,
    input  logic              shed_n,
    input  logic [NPORTS-1:0] hw_off_n,
    output logic [NPORTS-1:0] port_off,
    output logic [NPORTS-1:0] en_clr
);
    localparam int LW = $clog2(LIMIT_CYC + 1) + 1;
    localparam int SW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        shed_st_e          state;
        logic [NPORTS-1:0] pending;
        logic [NPORTS-1:0] clr;
        logic [LW-1:0]     lat;
    } seq_t;

    seq_t              r_d, r_q;
    logic              fall, ready, load;
    logic [NPORTS-1:0] cand, grant, low_mask;

    shed_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n(shed_n), .fall(fall)
    );

    shed_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(load), .ready(ready)
    );

    assign cand = r_q.pending & port_on;

    shed_lowest_pick #(.N(NPORTS)) u_pick (
        .req(cand), .grant(grant), .at_or_below(low_mask)
    );

    always_comb begin
        r_d     = r_q;
        r_d.clr = '0;
        load    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                r_d.lat = '0;
                if (fall) begin
                    r_d.state   = ST_BUSY;
                    r_d.pending = ~prio_hi;
                end
            end
            ST_BUSY: begin
                if (r_q.lat != '1) r_d.lat = r_q.lat + 1'b1;
                if (cand == '0) begin
                    r_d.state   = ST_IDLE;
                    r_d.pending = '0;
                end else if (ready) begin
                    r_d.clr     = grant;
                    r_d.pending = r_q.pending & ~low_mask;
                    load        = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.pending <= '0;
            r_q.clr     <= '0;
            r_q.lat     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_clr   = r_q.clr;
    assign port_off = r_q.clr | ~hw_off_n;

    // cycles since the last shed pulse, saturating (assertion support)
    logic [SW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_q <= SW'(GAP_CYC);
        else if (|en_clr)            since_q <= '0;
        else if (since_q != SW'(GAP_CYC)) since_q <= since_q + 1'b1;
    end

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |-> (since_q >= SW'(GAP_CYC - 1)));

    p_lowprio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |-> ((en_clr & $past(r_q.pending)) == en_clr));

    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_clr) |-> ((r_q.pending & (en_clr | (en_clr - 1'b1))) == '0));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BUSY) |-> (r_q.lat <= LW'(LIMIT_CYC)));

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_clr));

    p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.state == ST_BUSY) |-> $past(fall));
endmodule

// File: tb/shed_seq_tb_top.sv
module shed_seq_tb_top;
    localparam int N   = 4;
    localparam int GAP = 60;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] prio_hi = '0;
    logic [N-1:0] port_on = '0;
    logic         shed_n = 1'b1;
    logic [N-1:0] hw_off_n = '1;
    logic [N-1:0] port_off, en_clr;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #5 clk = ~clk;

    shed_seq #(.NPORTS(N), .GAP_CYC(GAP), .LIMIT_CYC(650), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .prio_hi(prio_hi), .port_on(port_on),
        .shed_n(shed_n), .hw_off_n(hw_off_n), .port_off(port_off), .en_clr(en_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive a shed request and compare pulse times per port with the model.
    task automatic run_shed(input logic [N-1:0] prio, input logic [N-1:0] on,
                            input int release_at, input string tag);
        int exp_t[N];
        int seen[N];
        int k = 0;
        @(negedge clk);
        prio_hi = prio;
        port_on = on;
        for (int i = 0; i < N; i++) begin
            seen[i] = -1;
            if (!prio[i] && on[i]) begin
                exp_t[i] = 4 + k * GAP;   // R6 first slot, R3 spacing, R4/R5 order
                k++;
            end else begin
                exp_t[i] = -1;            // R2 / R5: never pulsed
            end
        end
        shed_n = 1'b0;
        for (int c = 1; c <= 320; c++) begin
            @(negedge clk);
            if (c == release_at) shed_n = 1'b1;   // R8
            chk(port_off == en_clr, {tag, " R7 off/clr together"}, port_off, en_clr);
            chk($countones(en_clr) <= 1, {tag, " R7 one port"}, $countones(en_clr), 1);
            for (int i = 0; i < N; i++) begin
                if (en_clr[i]) begin
                    if (seen[i] >= 0)
                        chk(1'b0, {tag, " R7 repeated pulse"}, c, seen[i]);
                    else
                        seen[i] = c;
                    port_on[i] = 1'b0;   // port turns off
                end
            end
        end
        for (int i = 0; i < N; i++)
            chk(seen[i] == exp_t[i], {tag, " R2/R3/R4/R5/R6 pulse cycle"}, seen[i], exp_t[i]);
        shed_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(port_off == '0, "R1 port_off after reset", port_off, 0);
        chk(en_clr == '0, "R1 en_clr after reset", en_clr, 0);
    endtask

    task automatic t_held_low();
        @(negedge clk);
        prio_hi = '0;
        port_on = '0;
        shed_n  = 1'b0;
        repeat (20) @(negedge clk);
        port_on = '1;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            chk(en_clr == '0, "R10 no shed while held low", en_clr, 0);
        end
        shed_n = 1'b1;
        port_on = '0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_hw_kill();
        @(negedge clk);
        hw_off_n = 4'b1011;
        #1;
        chk(port_off == 4'b0100, "R9 hw kill same cycle", port_off, 4);
        chk(en_clr == '0, "R9 no enable clear", en_clr, 0);
        @(negedge clk);
        chk(port_off == 4'b0100, "R9 hw kill held", port_off, 4);
        hw_off_n = '1;
        #1;
        chk(port_off == '0, "R9 hw release", port_off, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_shed(4'b0000, 4'b1111, 0, "all_low");
        run_shed(4'b0101, 4'b1111, 0, "mixed_prio");
        run_shed(4'b0000, 4'b1010, 0, "skip_off");
        run_shed(4'b0000, 4'b1111, 10, "release_mid");
        run_shed(4'b1111, 4'b1111, 0, "all_high");
        t_held_low();
        t_hw_kill();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule